// File: doc/BRIEF.md
# Two-Bit Saturating Branch Direction Predictor

This block holds a direct-mapped table of 2-bit saturating counters and answers "taken or not taken?" for the instruction being fetched. The lookup port takes the fetch address and returns a direction in the same cycle, so the fetch stage can steer the next fetch before the instruction is decoded. The update port takes the address of a resolved branch and its real outcome, and moves the addressed counter one step toward that outcome.

Entries carry no tag. Two branches whose word addresses agree in the low index bits share one counter and can disturb each other's history. Each counter has hysteresis, so one surprise does not reverse a strongly held direction. As a result, a loop-closing branch costs a single misprediction per loop exit. A 1-bit scheme would cost two: one at the exit and one on re-entry.

The update port is a valid/ready stream whose ready is always high. The table accepts one update every cycle, so an upstream resolver never stalls on it. The lookup port is a plain query. The prediction output carries a valid that mirrors the lookup valid, and it has no ready, because a prediction cannot be held back.

Top module: `bp2_predictor`

## Requirements
- R1: After reset every counter holds 01 (weakly not-taken), so any lookup predicts not-taken. A single taken update to an entry then makes that entry predict taken.
- R2: The prediction is combinational from the lookup address. It equals bit 1 of the counter selected by PC[IDX_BITS+1:2], in the same cycle.
- R3: An accepted update with outcome taken raises the counter by one. At 11 the counter stays at 11.
- R4: An accepted update with outcome not-taken lowers the counter by one. At 00 the counter stays at 00.
- R5: From a strong state (00 or 11), the predicted direction changes only after two consecutive opposite outcomes.
- R6: For a loop branch repeating N taken outcomes followed by one not-taken outcome, each loop exit after the first entry mispredicts exactly once, and re-entry predicts correctly.
- R7: Addresses that differ only in bits [1:0] or in bits above IDX_BITS+1 select the same counter. An update through one of them changes the prediction seen through the other.
- R8: When a lookup and an update select the same entry in one cycle, the lookup returns the value held before the update. The new value is visible from the next cycle.
- R9: upd_ready is always 1. A cycle with upd_valid low leaves every counter unchanged, whatever upd_pc and upd_taken hold.
- R10: pred_valid equals lk_valid. While lk_valid is 0, pred_taken is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_pc | input | PC_W | Fetch address to predict |
| pred_valid | output | 1 | Prediction valid (follows lk_valid) |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | Resolved-branch update valid |
| upd_ready | output | 1 | Update accepted (always 1) |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The assertions assume that the lookup and update inputs are known values on every clock edge outside reset. They also assume PC_W is at least IDX_BITS+2, so that the index field exists. The stimulus drives every input to a defined value on each falling edge, including idle cycles where upd_valid is low. During those idle cycles upd_pc and upd_taken are deliberately left at values that would change a counter if they were accepted. Addresses are built by placing the index in bits [IDX_BITS+1:2], with chosen values in the alias and offset bits, so every access stays within the decoded field.

// File: rtl/bp2_pkg.sv
package bp2_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_STRONG_NT = 2'b00;
  localparam ctr_t CTR_WEAK_NT   = 2'b01;
  localparam ctr_t CTR_WEAK_T    = 2'b10;
  localparam ctr_t CTR_STRONG_T  = 2'b11;

  // One saturating step toward the observed outcome
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == CTR_STRONG_T)  ? cur : cur + 2'd1;
    else       nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
    return nxt;
  endfunction
endpackage

// File: rtl/bp2_index.sv
module bp2_index #(
  parameter int PC_W     = 32,
  parameter int IDX_BITS = 6
) (
  input  logic [PC_W-1:0]     pc,
  output logic [IDX_BITS-1:0] idx
);
  // word-aligned: offset bits carry no information
  assign idx = pc[IDX_BITS+1:2];

  logic unused_bits;
  assign unused_bits = ^{pc[PC_W-1:IDX_BITS+2], pc[1:0]};
endmodule

// File: rtl/bp2_counter_bank.sv
module bp2_counter_bank
  import bp2_pkg::*;
#(
  parameter int IDX_BITS = 6,
  localparam int DEPTH   = 1 << IDX_BITS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [IDX_BITS-1:0]        widx,
  input  logic                       wtaken,
  output logic [DEPTH-1:0][1:0]      ctrs
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    ctr_t state_q;
    logic hit;
    assign hit = we && (widx == IDX_BITS'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)   state_q <= CTR_WEAK_NT;
      else if (hit) state_q <= ctr_step(state_q, wtaken);
    end
    assign ctrs[g] = state_q;
  end
endmodule

// File: rtl/bp2_predictor.sv
module bp2_predictor #(
  parameter int PC_W     = 32,
  parameter int IDX_BITS = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  output logic            pred_valid,
  output logic            pred_taken,
  input  logic            upd_valid,
  output logic            upd_ready,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  localparam int DEPTH = 1 << IDX_BITS;

  logic [IDX_BITS-1:0]   lk_idx;
  logic [IDX_BITS-1:0]   upd_idx;
  logic [DEPTH-1:0][1:0] table_q;

  bp2_index #(.PC_W(PC_W), .IDX_BITS(IDX_BITS)) u_lk_idx  (.pc(lk_pc),  .idx(lk_idx));
  bp2_index #(.PC_W(PC_W), .IDX_BITS(IDX_BITS)) u_upd_idx (.pc(upd_pc), .idx(upd_idx));

  assign upd_ready = 1'b1;

  bp2_counter_bank #(.IDX_BITS(IDX_BITS)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (upd_valid && upd_ready),
    .widx   (upd_idx),
    .wtaken (upd_taken),
    .ctrs   (table_q)
  );

  // read before write: the bank presents registered state only
  assign pred_valid = lk_valid;
  assign pred_taken = lk_valid && table_q[lk_idx][1];
endmodule

// File: rtl/bp2_predictor_chk.sv
module bp2_predictor_chk #(
  parameter int PC_W     = 32,
  parameter int IDX_BITS = 6,
  localparam int DEPTH   = 1 << IDX_BITS
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  lk_valid,
  input logic [PC_W-1:0]       lk_pc,
  input logic                  pred_valid,
  input logic                  pred_taken,
  input logic                  upd_valid,
  input logic                  upd_ready,
  input logic [PC_W-1:0]       upd_pc,
  input logic                  upd_taken,
  input logic [DEPTH-1:0][1:0] table_q
);
  logic [IDX_BITS-1:0] ui, li;
  assign ui = upd_pc[IDX_BITS+1:2];
  assign li = lk_pc[IDX_BITS+1:2];

  assert_taken_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && upd_taken && table_q[ui] != 2'b11 |=>
      table_q[$past(ui)] == $past(table_q[ui]) + 2'd1);

  assert_taken_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && upd_taken && table_q[ui] == 2'b11 |=> table_q[$past(ui)] == 2'b11);

  assert_nt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && !upd_taken && table_q[ui] != 2'b00 |=>
      table_q[$past(ui)] == $past(table_q[ui]) - 2'd1);

  assert_nt_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && !upd_taken && table_q[ui] == 2'b00 |=> table_q[$past(ui)] == 2'b00);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(table_q));

  assert_ready_R9: assert property (@(posedge clk) disable iff (!rst_n) upd_ready);

  assert_pred_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> pred_valid && (pred_taken == table_q[li][1]));

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !pred_valid && !pred_taken);
endmodule

bind bp2_predictor bp2_predictor_chk #(.PC_W(PC_W), .IDX_BITS(IDX_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
  .pred_valid(pred_valid), .pred_taken(pred_taken), .upd_valid(upd_valid),
  .upd_ready(upd_ready), .upd_pc(upd_pc), .upd_taken(upd_taken), .table_q(table_q)
);

// File: tb/bp2_predictor_test.sv
`timescale 1ns/1ps
module bp2_predictor_test;
  localparam int PC_W = 32;
  localparam int IDX_BITS = 6;
  localparam int DEPTH = 1 << IDX_BITS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, upd_valid = 1'b0, upd_taken = 1'b0;
  logic [PC_W-1:0] lk_pc = '0, upd_pc = '0;
  logic pred_valid, pred_taken, upd_ready;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int model [DEPTH];

  always #2 clk = ~clk;

  bp2_predictor #(.PC_W(PC_W), .IDX_BITS(IDX_BITS)) uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .upd_valid(upd_valid),
    .upd_ready(upd_ready), .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  function automatic logic [PC_W-1:0] mkpc(int idx, int hi, int off);
    return PC_W'((hi << (IDX_BITS + 2)) | (idx << 2) | off);
  endfunction

  function automatic int ix(logic [PC_W-1:0] pc);
    return int'((pc >> 2) % DEPTH);
  endfunction

  task automatic check(logic act, logic exp, string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // One clock: drive on negedge, compare against model, then advance model
  task automatic step(logic lv, logic [PC_W-1:0] lp, logic uv,
                      logic [PC_W-1:0] up, logic ut, string req, output logic got);
    @(negedge clk);
    lk_valid = lv; lk_pc = lp; upd_valid = uv; upd_pc = up; upd_taken = ut;
    #1;
    check(pred_valid, lv, "R10");
    check(upd_ready, 1'b1, "R9");
    check(pred_taken, lv ? (model[ix(lp)] >= 2) : 1'b0, req);
    got = pred_taken;
    @(posedge clk);
    if (uv) begin
      if (ut && model[ix(up)] < 3) model[ix(up)]++;
      if (!ut && model[ix(up)] > 0) model[ix(up)]--;
    end
  endtask

  task automatic upd(logic [PC_W-1:0] pc, logic t);
    logic g;
    step(1'b0, '0, 1'b1, pc, t, "R10", g);
  endtask

  task automatic look(logic [PC_W-1:0] pc, string req, output logic g);
    step(1'b1, pc, 1'b0, pc ^ 32'h4, 1'b1, req, g);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic g;
    int miss;
    for (int i = 0; i < DEPTH; i++) model[i] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state predicts not-taken everywhere
    for (int i = 0; i < DEPTH; i += 9) begin
      look(mkpc(i, 0, 0), "R1", g);
      check(g, 1'b0, "R1");
    end
    upd(mkpc(3, 0, 0), 1'b1);
    look(mkpc(3, 0, 0), "R1", g);
    check(g, 1'b1, "R1");

    // R2 + R10: idle lookup quiet, prediction same cycle
    step(1'b0, mkpc(3, 0, 0), 1'b0, '0, 1'b0, "R10", g);
    look(mkpc(3, 0, 0), "R2", g);

    // R3: saturate high, R5: two misses to flip
    repeat (4) upd(mkpc(5, 0, 0), 1'b1);
    upd(mkpc(5, 0, 0), 1'b0);
    look(mkpc(5, 0, 0), "R5", g);
    check(g, 1'b1, "R5");
    upd(mkpc(5, 0, 0), 1'b0);
    look(mkpc(5, 0, 0), "R5", g);
    check(g, 1'b0, "R5");

    // R4: saturate low, then one taken stays not-taken
    repeat (5) upd(mkpc(6, 0, 0), 1'b0);
    upd(mkpc(6, 0, 0), 1'b1);
    look(mkpc(6, 0, 0), "R4", g);
    check(g, 1'b0, "R4");

    // R7: alias via high bits and offset bits
    repeat (3) upd(mkpc(9, 5, 0), 1'b1);
    look(mkpc(9, 0, 2), "R7", g);
    check(g, 1'b1, "R7");
    look(mkpc(10, 0, 0), "R7", g);
    check(g, 1'b0, "R7");

    // R8: collision returns old value
    step(1'b1, mkpc(12, 0, 0), 1'b1, mkpc(12, 1, 0), 1'b1, "R8", g);
    check(g, 1'b0, "R8");
    look(mkpc(12, 0, 0), "R8", g);
    check(g, 1'b1, "R8");

    // R9: upd_valid low with live-looking fields changes nothing
    step(1'b1, mkpc(20, 0, 0), 1'b0, mkpc(20, 0, 0), 1'b1, "R9", g);
    look(mkpc(20, 0, 0), "R9", g);
    check(g, 1'b0, "R9");

    // R6: loop branch, 8 taken + 1 exit, three passes
    miss = 0;
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < 9; k++) begin
        logic out;
        out = (k < 8);
        step(1'b1, mkpc(30, 0, 0), 1'b1, mkpc(30, 0, 0), out, "R6", g);
        if (g != out) miss++;
      end
    end
    check(miss == 4, 1'b1, "R6");

    // mixed traffic compared against the model every clock (R2)
    for (int i = 0; i < 400; i++) begin
      step(1'b1, mkpc((i * 7) % DEPTH, i % 3, i % 4), (i % 3) != 0,
           mkpc((i * 5) % DEPTH, i % 2, 0), ((i * 11) % 5) < 3, "R2", g);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule